// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked on-chip requester and an external asynchronous 256K x 16 static RAM. The RAM has an active-low chip select, write strobe and output enable, plus two active-low byte-lane enables. A request carries an 18-bit word address, 16 bits of write data, two byte-enable bits and a direction bit. The controller turns it into a fixed strobe sequence on the RAM pins and reports completion with a one-cycle done pulse. Read data is returned with that pulse.

Each access runs through four phases: setup, active, hold and back to idle. Address, chip select and lane enables settle in setup. The active phase holds the write strobe or the output enable low for a parameterised number of clocks. The hold phase releases the write strobe while chip select, the lanes, the address and the write data stay put, so the RAM captures the data on the rising write strobe. While idle, chip select stays high, which keeps the RAM in low-power standby. The shared data bus is exposed as separate out, enable and in signals.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset and whenever the controller is idle, mem_cs_no, mem_we_no, mem_oe_no, mem_lb_no and mem_ub_no are all 1, mem_dq_oe_o is 0, ready_o and standby_o are 1, and done_o is 0 unless an access has just finished.
- R2: mem_we_no is low only while mem_cs_no and at least one lane enable are low. mem_oe_no stays high for the whole of every write access.
- R3: While mem_cs_no is low, mem_addr_o equals the accepted request address and does not change. This holds at both address extremes, 0 and 0x3FFFF.
- R4: During a write, mem_dq_oe_o is high and mem_dq_o holds the request data from the first cycle with chip select low until chip select returns high. mem_we_no rises one full cycle before mem_cs_no does.
- R5: The write strobe is low for WR_WAIT cycles and the read output enable is low for RD_WAIT cycles. Each count is the access time in ps divided by the clock period in ps, rounded up, with a minimum of 1. With the defaults (10000 ps clock, 12000 ps write pulse, 15000 ps read access) both counts are 2.
- R6: be_i[0] drives mem_lb_no and covers data bits 7:0. be_i[1] drives mem_ub_no and covers bits 15:8. Only enabled lanes are written.
- R7: On a read, rdata_o takes bus bits for the enabled lanes and zero for the disabled lanes. The value is valid in the done cycle and is held until the next read finishes.
- R8: done_o is high for exactly one cycle. For a request with a lane enabled, done_o rises at the (N+2)th rising edge after the accepting edge, where N is WR_WAIT for writes and RD_WAIT for reads.
- R9: A request is accepted only when req_i and ready_o are both 1. ready_o is 0 from the accepting edge until the done cycle, and requests made in that window are ignored.
- R10: A request with be_i = 2'b00 completes with done_o at the first edge after acceptance. mem_cs_no stays high and the RAM contents are left unchanged.
- R11: mem_dq_oe_o and a low mem_oe_no never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 18 | Word address |
| wdata_i | input | 16 | Write data |
| be_i | input | 2 | Byte enables, bit 0 low byte, bit 1 high byte |
| ready_o | output | 1 | Idle, able to accept a request |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read data, disabled lanes zero |
| mem_addr_o | output | 18 | RAM address |
| mem_cs_no | output | 1 | RAM chip select, active low |
| mem_we_no | output | 1 | RAM write strobe, active low |
| mem_oe_no | output | 1 | RAM output enable, active low |
| mem_lb_no | output | 1 | RAM low-byte enable, active low |
| mem_ub_no | output | 1 | RAM high-byte enable, active low |
| mem_dq_o | output | 16 | Data driven toward the RAM |
| mem_dq_oe_o | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 16 | Data returned from the RAM |
| standby_o | output | 1 | RAM held in low-power standby |

## Verification
The RAM model returns junk until the output enable has been low long enough. A wait count that is one short therefore reads back garbage, and a missing hold phase lets chip select rise together with the write strobe, which the model reports as an ordering fault. Single-lane writes to a word already filled on both lanes expose lane swaps or writes to both lanes, because the untouched byte would change. A request poked in while the controller is busy, and a request with no lanes enabled, expose a controller that accepts out of turn or that touches the bus for an empty request. Random mixes over a small address set, together with writes and reads at the top address, check data integrity and completion latency across back-to-back requests.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_ACTIVE, ST_HOLD} sram_st_e;

  function automatic int wait_cycles(input int need_ps, input int clk_ps);
    int c;
    c = (need_ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction
endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int RD_WAIT = 2,
  parameter int WR_WAIT = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  logic     empty_i,
  input  logic     wr_i,
  output sram_st_e state_o,
  output logic     cap_o,
  output logic     done_o
);
  localparam int MAX_WAIT = (RD_WAIT > WR_WAIT) ? RD_WAIT : WR_WAIT;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);
  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_WAIT - 1);
  localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_WAIT - 1);

  sram_st_e         st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          if (empty_i) done_q <= 1'b1;  // nothing to move: finish at once
          else         st_q   <= ST_SETUP;
        end
        ST_SETUP: begin
          st_q  <= ST_ACTIVE;
          cnt_q <= wr_i ? WR_LOAD : RD_LOAD;
        end
        ST_ACTIVE: begin
          if (cnt_q == '0) st_q <= ST_HOLD;
          else             cnt_q <= cnt_q - 1'b1;
        end
        ST_HOLD: begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = st_q;
  assign cap_o   = (st_q == ST_ACTIVE) && (cnt_q == '0) && !wr_i;
  assign done_o  = done_q;
endmodule

// File: rtl/sram_ctrl_lanes.sv
module sram_ctrl_lanes #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [1:0]        be_i,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic              wr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [1:0]        be_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int LANE_W = DATA_W / 2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
      be_o    <= '0;
    end else if (load_i) begin
      wr_o    <= wr_i;
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
      be_o    <= be_i;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    rdata_o[g*LANE_W +: LANE_W] <= '0;
      else if (cap_i) rdata_o[g*LANE_W +: LANE_W] <= be_o[g] ? dq_i[g*LANE_W +: LANE_W] : '0;
    end
  end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int DATA_W  = 16,
  parameter int CLK_PS  = 10000,
  parameter int WR_PW_PS = 12000,
  parameter int RD_ACC_PS = 15000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [1:0]        be_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_cs_no,
  output logic              mem_we_no,
  output logic              mem_oe_no,
  output logic              mem_lb_no,
  output logic              mem_ub_no,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              standby_o
);
  localparam int RD_WAIT = wait_cycles(RD_ACC_PS, CLK_PS);
  localparam int WR_WAIT = wait_cycles(WR_PW_PS, CLK_PS);

  sram_st_e   st;
  logic       start, cap, wr_q, busy;
  logic [1:0] be_q;

  assign start = req_i && ready_o;

  sram_ctrl_seq #(.RD_WAIT(RD_WAIT), .WR_WAIT(WR_WAIT)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .empty_i (be_i == 2'b00),
    .wr_i    (wr_q),
    .state_o (st),
    .cap_o   (cap),
    .done_o  (done_o)
  );

  sram_ctrl_lanes #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lanes (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (start),
    .wr_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .be_i    (be_i),
    .cap_i   (cap),
    .dq_i    (mem_dq_i),
    .wr_o    (wr_q),
    .addr_o  (mem_addr_o),
    .wdata_o (mem_dq_o),
    .be_o    (be_q),
    .rdata_o (rdata_o)
  );

  assign busy        = (st != ST_IDLE);
  assign ready_o     = !busy;
  assign standby_o   = !busy;
  assign mem_cs_no   = !busy;
  assign mem_lb_no   = !(busy && be_q[0]);
  assign mem_ub_no   = !(busy && be_q[1]);
  assign mem_we_no   = !((st == ST_ACTIVE) && wr_q);
  assign mem_oe_no   = !((st == ST_ACTIVE) && !wr_q);
  assign mem_dq_oe_o = busy && wr_q;  // SETUP through HOLD of a write
endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [1:0]        be_i,
  input logic              ready_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_cs_no,
  input logic              mem_we_no,
  input logic              mem_oe_no,
  input logic              mem_lb_no,
  input logic              mem_ub_no,
  input logic              mem_dq_oe_o,
  input logic              standby_o
);
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (mem_cs_no && mem_we_no && mem_oe_no && mem_lb_no && mem_ub_no
                 && !mem_dq_oe_o && standby_o));

  a_r2_we_selected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (!mem_cs_no && (!mem_lb_no || !mem_ub_no)));

  a_r2_oe_off_in_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> mem_oe_no);

  a_r3_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_cs_no && $past(!mem_cs_no)) |-> $stable(mem_addr_o));

  a_r4_we_release_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> (!mem_cs_no && mem_dq_oe_o));

  a_r8_done_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ready_o);

  a_r9_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o && (be_i != 2'b00)) |=> !ready_o);

  a_r11_no_contention: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_no);
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .be_i        (be_i),
  .ready_o     (ready_o),
  .done_o      (done_o),
  .mem_addr_o  (mem_addr_o),
  .mem_cs_no   (mem_cs_no),
  .mem_we_no   (mem_we_no),
  .mem_oe_no   (mem_oe_no),
  .mem_lb_no   (mem_lb_no),
  .mem_ub_no   (mem_ub_no),
  .mem_dq_oe_o (mem_dq_oe_o),
  .standby_o   (standby_o)
);

// File: tb/sim_sram_async_ctrl.sv
module sim_sram_async_ctrl;
  localparam int CLK_PS  = 10000;
  localparam int T_HALF  = 5;
  localparam int WR_WAIT = 2;  // ceil(12000/10000)
  localparam int RD_WAIT = 2;  // ceil(15000/10000)
  localparam int ACC_CYC = 2;  // cycles of OE low before model data is valid

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [17:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  be = '0;
  logic        ready, done, cs_n, we_n, oe_n, lb_n, ub_n, dq_oe, standby;
  logic [15:0] rdata, dq_o, dq_i;
  logic [17:0] maddr;

  int n_chk = 0, n_fail = 0, cyc_all = 0;

  always #T_HALF clk = ~clk;

  sram_async_ctrl #(.CLK_PS(CLK_PS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .be_i(be), .ready_o(ready), .done_o(done), .rdata_o(rdata),
    .mem_addr_o(maddr), .mem_cs_no(cs_n), .mem_we_no(we_n), .mem_oe_no(oe_n),
    .mem_lb_no(lb_n), .mem_ub_no(ub_n), .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe),
    .mem_dq_i(dq_i), .standby_o(standby)
  );

  // ---------------- RAM model ----------------
  logic [15:0] ram [int];
  logic [15:0] shadow [int];
  int acc_cnt = 0, we_run = 0, oe_run = 0, last_we = 0, last_oe = 0;
  int cs_low_cyc = 0, v_cont = 0, v_oew = 0, v_addr = 0, v_data = 0, v_order = 0;
  logic        p_cs_low = 1'b0, p_dq_oe = 1'b0, p_we_low = 1'b0;
  logic [17:0] p_addr = '0;
  logic [15:0] p_dq = '0;

  function automatic logic [15:0] ram_rd(input logic [17:0] a);
    return ram.exists(int'(a)) ? ram[int'(a)] : 16'h0000;
  endfunction

  always_comb begin
    dq_i = 16'hDEAD;
    if (!cs_n && !oe_n && we_n && acc_cnt >= ACC_CYC) begin
      dq_i[7:0]  = lb_n ? 8'hEE : ram_rd(maddr)[7:0];
      dq_i[15:8] = ub_n ? 8'hEE : ram_rd(maddr)[15:8];
    end
  end

  always @(posedge we_n) begin
    if (!cs_n && dq_oe) begin
      logic [15:0] w;
      w = ram_rd(maddr);
      if (!lb_n) w[7:0]  = dq_o[7:0];
      if (!ub_n) w[15:8] = dq_o[15:8];
      ram[int'(maddr)] = w;
    end
  end

  always @(negedge clk) begin
    cyc_all <= cyc_all + 1;
    acc_cnt <= (!cs_n && !oe_n && we_n) ? acc_cnt + 1 : 0;
    if (!we_n) we_run <= we_run + 1;
    else if (we_run > 0) begin last_we <= we_run; we_run <= 0; end
    if (!oe_n) oe_run <= oe_run + 1;
    else if (oe_run > 0) begin last_oe <= oe_run; oe_run <= 0; end
    if (!cs_n) cs_low_cyc <= cs_low_cyc + 1;
    if (dq_oe && !oe_n) v_cont <= v_cont + 1;
    if (!we_n && !oe_n) v_oew <= v_oew + 1;
    if (!cs_n && p_cs_low && maddr != p_addr) v_addr <= v_addr + 1;
    if (dq_oe && p_dq_oe && dq_o != p_dq) v_data <= v_data + 1;
    if (p_we_low && we_n && cs_n) v_order <= v_order + 1;
    if (!we_n && (cs_n || (lb_n && ub_n))) v_order <= v_order + 1;
    p_cs_low <= !cs_n; p_addr <= maddr; p_dq_oe <= dq_oe; p_dq <= dq_o; p_we_low <= !we_n;
  end

  // ---------------- bench helpers ----------------
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] sh_rd(input logic [17:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
  endfunction

  function automatic logic [15:0] exp_rd(input logic [17:0] a, input logic [1:0] b);
    logic [15:0] w;
    w = sh_rd(a);
    return {b[1] ? w[15:8] : 8'h00, b[0] ? w[7:0] : 8'h00};
  endfunction

  task automatic sh_wr(input logic [17:0] a, input logic [15:0] d, input logic [1:0] b);
    logic [15:0] w;
    w = sh_rd(a);
    if (b[0]) w[7:0]  = d[7:0];
    if (b[1]) w[15:8] = d[15:8];
    shadow[int'(a)] = w;
  endtask

  // Issue at a negedge with ready high; returns at the negedge where done is seen.
  task automatic do_op(input bit wr, input logic [17:0] a, input logic [15:0] d,
                       input logic [1:0] b, input bit poke);
    int cyc, exp_cyc;
    req = 1'b1; we = wr; addr = a; wdata = d; be = b;
    @(negedge clk);
    req = 1'b0;
    cyc = 1;
    exp_cyc = (b == 2'b00) ? 1 : (wr ? WR_WAIT : RD_WAIT) + 3;
    while (!done && cyc < 50) begin
      if (poke && cyc == 1) begin
        req = 1'b1; we = 1'b1; addr = 18'h00777; wdata = 16'hBAD0; be = 2'b11;
      end else req = 1'b0;
      @(negedge clk);
      cyc++;
    end
    req = 1'b0;
    chk(cyc == exp_cyc, "R8 done latency", cyc, exp_cyc);
    if (wr) sh_wr(a, d, b);
    else if (b != 2'b00) chk(rdata == exp_rd(a, b), "R7 read data", rdata, exp_rd(a, b));
  endtask

  // ---------------- stimulus ----------------
  initial begin
    int seed;
    logic [15:0] held;
    int cs_before;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    chk(cs_n && we_n && oe_n && lb_n && ub_n, "R1 strobes high in reset", {cs_n, we_n, oe_n, lb_n, ub_n}, 5'h1F);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready && standby && !dq_oe && !done, "R1 idle state", {ready, standby, dq_oe, done}, 4'b1100);

    // R6 / R7: full write then single-lane updates
    do_op(1'b1, 18'h00010, 16'h1234, 2'b11, 1'b0);
    chk(last_we == WR_WAIT, "R5 write pulse width", last_we, WR_WAIT);
    do_op(1'b0, 18'h00010, 16'h0, 2'b11, 1'b0);
    chk(last_oe == RD_WAIT, "R5 read enable width", last_oe, RD_WAIT);
    do_op(1'b1, 18'h00010, 16'hAB99, 2'b01, 1'b0);
    do_op(1'b0, 18'h00010, 16'h0, 2'b11, 1'b0);
    chk(rdata == 16'h1299, "R6 low lane only written", rdata, 16'h1299);
    do_op(1'b1, 18'h00010, 16'h77CC, 2'b10, 1'b0);
    do_op(1'b0, 18'h00010, 16'h0, 2'b11, 1'b0);
    chk(rdata == 16'h7799, "R6 high lane only written", rdata, 16'h7799);
    do_op(1'b0, 18'h00010, 16'h0, 2'b10, 1'b0);
    chk(rdata == 16'h7700, "R7 disabled lane reads zero", rdata, 16'h7700);

    // R7: rdata held across a following write
    held = rdata;
    do_op(1'b1, 18'h00011, 16'h5555, 2'b11, 1'b0);
    chk(rdata == held, "R7 rdata held over write", rdata, held);

    // R8: single-cycle done
    @(negedge clk);
    chk(!done, "R8 done one cycle", done, 0);

    // R3: address extremes
    do_op(1'b1, 18'h3FFFF, 16'hF00D, 2'b11, 1'b0);
    do_op(1'b1, 18'h00000, 16'h0F0F, 2'b11, 1'b0);
    do_op(1'b0, 18'h3FFFF, 16'h0, 2'b11, 1'b0);
    chk(rdata == 16'hF00D, "R3 top address", rdata, 16'hF00D);

    // R9: request while busy is ignored
    do_op(1'b0, 18'h00011, 16'h0, 2'b11, 1'b1);
    repeat (4) begin
      @(negedge clk);
      chk(!done && ready, "R9 no extra access", {done, ready}, 2'b01);
    end
    do_op(1'b0, 18'h00777, 16'h0, 2'b11, 1'b0);
    chk(rdata == 16'h0000, "R9 busy request not written", rdata, 16'h0000);

    // R10: empty request
    cs_before = cs_low_cyc;
    do_op(1'b1, 18'h00011, 16'hFFFF, 2'b00, 1'b0);
    @(negedge clk);
    chk(cs_low_cyc == cs_before, "R10 no chip select", cs_low_cyc, cs_before);
    do_op(1'b0, 18'h00011, 16'h0, 2'b11, 1'b0);
    chk(rdata == 16'h5555, "R10 memory unchanged", rdata, 16'h5555);

    // random mix, back to back
    for (int i = 0; i < 200; i++) begin
      logic [17:0] a;
      a = ($urandom_range(0, 9) == 0) ? 18'h3FFFF : 18'($urandom_range(0, 15));
      do_op(1'($urandom_range(0, 1)), a, 16'($urandom), 2'($urandom_range(0, 3)), 1'b0);
    end

    // bus protocol monitors
    chk(v_cont == 0, "R11 bus contention", v_cont, 0);
    chk(v_oew == 0, "R2 OE low during write", v_oew, 0);
    chk(v_order == 0, "R4 strobe ordering / R2 select", v_order, 0);
    chk(v_addr == 0, "R3 address moved", v_addr, 0);
    chk(v_data == 0, "R4 write data moved", v_data, 0);
    chk(ready && standby && cs_n, "R1 idle at end", {ready, standby, cs_n}, 3'b111);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait (cyc_all > 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected<150000", cyc_all);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule